// File: doc/BRIEF.md
# Receive request packer

This block handles the receive-only side of a serial port operating in half duplex. Software starts a reception by writing a byte count. The block then takes exactly that many bytes from a serial byte source and sends nothing the other way. It collects the bytes into 32-bit words and pushes each word to an external receive FIFO. The bytes are counted in bytes whatever the serial frame width is. A 16-bit remaining-count output shows how many requested bytes have not yet arrived.

The first byte of a word goes to the most significant position. When the request ends before a word is full, the short word is pushed anyway. Its bytes sit in the low-order positions, with the earliest byte at bit offset (valid − 1) × 8. A 3-bit valid-byte count is pushed with every word so that software can unpack the short tail. A single request can never exceed the FIFO depth × 4 bytes, and longer transfers are made by issuing further requests. A one-cycle done pulse marks the push of the last word of a request.

The controller has three states. `RQ_IDLE` waits for a request. `RQ_GATHER` takes bytes. `RQ_DRAIN` holds a finished word until the FIFO accepts it. The transitions are as follows:
- IDLE→GATHER on a write with a count other than zero.
- GATHER→DRAIN when the fourth byte of a word, or the last byte of the request, is taken.
- DRAIN→GATHER on a push while bytes are still owed.
- DRAIN→IDLE on the push that empties the count, which raises done.

Top module: `rxq_request_packer`

## Requirements
- R1: After reset, `busy`, `byte_ready`, `fifo_push` and `done` are 0 and `remaining` is 0.
- R2: A write (`req_we`=1) while idle with a count N in 1..FIFO_DEPTH×4 sets `remaining` to N and `busy` to 1 on the following cycle.
- R3: A write while idle with a count above FIFO_DEPTH×4 (32 by default) loads FIFO_DEPTH×4. After it, exactly that many bytes are taken.
- R4: A write of count 0 while idle is ignored: `busy`, `byte_ready` and `remaining` stay 0.
- R5: A write while `busy` is 1 is ignored. `remaining` and the total number of bytes taken follow only the original request.
- R6: Each cycle with `byte_valid` and `byte_ready` both 1 takes one byte and lowers `remaining` by exactly one.
- R7: A full word carries four bytes. The first taken byte is in bits 31:24 and the last in bits 7:0, and `fifo_nbytes` is 4.
- R8: A final word of k<4 bytes has `fifo_nbytes`=k. Its earliest byte is at bits (k−1)×8+7:(k−1)×8, the latest at bits 7:0, and the bits above are 0.
- R9: While `fifo_full` is 1, `fifo_push` stays 0. A finished word waits and `byte_ready` is 0, so no byte is lost.
- R10: `done` is a one-cycle pulse in the same cycle as the push of a request's final word. On the next cycle the block is idle with `remaining` 0.
- R11: `byte_ready` is 1 only while a request is in progress and no finished word is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_we | input | 1 | Request write strobe |
| req_count | input | CNT_W | Requested byte count |
| remaining | output | CNT_W | Bytes still to be received |
| busy | output | 1 | A request is in progress |
| byte_valid | input | 1 | Byte source has a byte |
| byte_data | input | 8 | Byte from the serial source |
| byte_ready | output | 1 | Block takes a byte this cycle if valid |
| fifo_push | output | 1 | Push strobe to the receive FIFO |
| fifo_word | output | 32 | Packed word, first byte most significant |
| fifo_nbytes | output | 3 | Valid bytes in the pushed word (1 to 4) |
| fifo_full | input | 1 | Receive FIFO cannot accept a word |
| done | output | 1 | Final word of the request pushed |

## Verification
Several rules hold on every cycle and are checked continuously:
- `remaining` falls by one for each byte taken.
- `remaining` never exceeds the cap.
- No push occurs while the FIFO is full.
- A pushed valid-byte count always lies between 1 and 4.
- `done` only ever appears together with the final push.
- A write made while busy leaves the count unchanged.

Other properties need the bench's scenarios with random byte gaps and FIFO back-pressure. These are the byte order inside each word, the placement of a short tail, the clamping of large requests, the rejection of a zero count, and the fact that every byte taken appears in a later word exactly once.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int BYTE_W     = 8;
    localparam int LANES      = 4;
    localparam int WORD_W     = BYTE_W * LANES;
    localparam int LANE_CNT_W = 3;

    typedef enum logic [1:0] {
        RQ_IDLE   = 2'd0,
        RQ_GATHER = 2'd1,
        RQ_DRAIN  = 2'd2
    } rq_state_e;
endpackage

// File: rtl/rxq_remaining.sv
module rxq_remaining #(
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] remaining,
    output logic             is_last,
    output logic             is_zero
);
    localparam int               CAP   = FIFO_DEPTH * rxq_pkg::LANES;
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

    logic [CNT_W-1:0] clamped;

    always_comb begin
        clamped = (load_val > CAP_V) ? CAP_V : load_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= clamped;
        end else if (dec) begin
            remaining <= remaining - CNT_W'(1);
        end
    end

    assign is_last = (remaining == CNT_W'(1));
    assign is_zero = (remaining == '0);

    // R6: a byte is never taken once the count is exhausted
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> remaining != '0);

    // R3: the count never rises above the cap
    a_r3_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
        remaining <= CAP_V);
endmodule

// File: rtl/rxq_packer.sv
module rxq_packer (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               shift_en,
    input  logic [rxq_pkg::BYTE_W-1:0]         byte_in,
    input  logic                               clear,
    output logic [rxq_pkg::WORD_W-1:0]         word,
    output logic [rxq_pkg::LANE_CNT_W-1:0]     fill
);
    localparam int BW = rxq_pkg::BYTE_W;
    localparam int WW = rxq_pkg::WORD_W;
    localparam int CW = rxq_pkg::LANE_CNT_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            fill <= '0;
        end else if (clear) begin
            word <= '0;
            fill <= '0;
        end else if (shift_en) begin
            word <= {word[WW-BW-1:0], byte_in};
            fill <= fill + CW'(1);
        end
    end

    // R7: no byte is shifted into a word that already holds four
    a_r7_no_shift_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> fill < CW'(rxq_pkg::LANES));

    // R7: the lane count stays within a word
    a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(rxq_pkg::LANES));
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_we,
    input  logic req_nonzero,
    input  logic byte_valid,
    input  logic fifo_full,
    input  logic fill_is_three,
    input  logic count_is_last,
    input  logic count_is_zero,
    output logic load,
    output logic take,
    output logic push,
    output logic clear,
    output logic byte_ready,
    output logic busy,
    output logic done
);
    rq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_IDLE: begin
                if (req_we && req_nonzero) state_d = RQ_GATHER;
            end
            RQ_GATHER: begin
                if (byte_valid && (fill_is_three || count_is_last)) state_d = RQ_DRAIN;
            end
            RQ_DRAIN: begin
                if (!fifo_full) state_d = count_is_zero ? RQ_IDLE : RQ_GATHER;
            end
            default: state_d = RQ_IDLE;
        endcase
    end

    always_comb begin
        load       = 1'b0;
        take       = 1'b0;
        push       = 1'b0;
        clear      = 1'b0;
        byte_ready = 1'b0;
        done       = 1'b0;
        busy       = (state_q != RQ_IDLE);
        unique case (state_q)
            RQ_IDLE: begin
                load = req_we && req_nonzero;
            end
            RQ_GATHER: begin
                byte_ready = 1'b1;
                take       = byte_valid;
            end
            RQ_DRAIN: begin
                push  = !fifo_full;
                clear = !fifo_full;
                done  = !fifo_full && count_is_zero;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    // R9: a full FIFO never receives a push
    a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !push);

    // R9: a waiting word keeps the byte source stalled
    a_r9_stall_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RQ_DRAIN && fifo_full) |=> (state_q == RQ_DRAIN && !byte_ready));

    // R10: after done the controller is idle
    a_r10_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> state_q == RQ_IDLE);

    // R11: nothing is clocked from the source while idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RQ_IDLE) |-> (!byte_ready && !push));
endmodule

// File: rtl/rxq_request_packer.sv
module rxq_request_packer #(
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_we,
    input  logic [CNT_W-1:0]                   req_count,
    output logic [CNT_W-1:0]                   remaining,
    output logic                               busy,
    input  logic                               byte_valid,
    input  logic [rxq_pkg::BYTE_W-1:0]         byte_data,
    output logic                               byte_ready,
    output logic                               fifo_push,
    output logic [rxq_pkg::WORD_W-1:0]         fifo_word,
    output logic [rxq_pkg::LANE_CNT_W-1:0]     fifo_nbytes,
    input  logic                               fifo_full,
    output logic                               done
);
    localparam int CW = rxq_pkg::LANE_CNT_W;

    logic load, take, clear;
    logic count_is_last, count_is_zero;

    rxq_remaining #(.CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_val  (req_count),
        .dec       (take),
        .remaining (remaining),
        .is_last   (count_is_last),
        .is_zero   (count_is_zero)
    );

    rxq_packer u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (take),
        .byte_in  (byte_data),
        .clear    (clear),
        .word     (fifo_word),
        .fill     (fifo_nbytes)
    );

    rxq_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_we        (req_we),
        .req_nonzero   (req_count != '0),
        .byte_valid    (byte_valid),
        .fifo_full     (fifo_full),
        .fill_is_three (fifo_nbytes == CW'(3)),
        .count_is_last (count_is_last),
        .count_is_zero (count_is_zero),
        .load          (load),
        .take          (take),
        .push          (fifo_push),
        .clear         (clear),
        .byte_ready    (byte_ready),
        .busy          (busy),
        .done          (done)
    );

    // R6: every accepted byte lowers the count by one
    a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready) |=> remaining == $past(remaining) - CNT_W'(1));

    // R5: a write during a request does not alter the count
    a_r5_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_we && !(byte_valid && byte_ready)) |=> remaining == $past(remaining));

    // R8: a pushed word carries between one and four bytes
    a_r8_nbytes_range: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (fifo_nbytes != '0 && fifo_nbytes <= CW'(4)));

    // R10: done only accompanies the final push
    a_r10_done_with_final_push: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fifo_push && remaining == '0));
endmodule

// File: tb/rxq_request_packer_tb_top.sv
`timescale 1ns/1ps
module rxq_request_packer_tb_top;
    localparam int CNT_W = 16;
    localparam int DEPTH = 8;
    localparam int CAP   = DEPTH * 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_count = '0;
    logic [15:0] remaining;
    logic        busy;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        byte_ready;
    logic        fifo_push;
    logic [31:0] fifo_word;
    logic [2:0]  fifo_nbytes;
    logic        fifo_full = 1'b0;
    logic        done;

    int total = 0;
    int bad = 0;
    logic [7:0] pend [4];
    int pcnt;

    always #2 clk = ~clk;

    rxq_request_packer #(.CNT_W(CNT_W), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_count(req_count),
        .remaining(remaining), .busy(busy), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_ready(byte_ready), .fifo_push(fifo_push),
        .fifo_word(fifo_word), .fifo_nbytes(fifo_nbytes), .fifo_full(fifo_full),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] place_bytes(input int k);
        logic [31:0] w = '0;
        for (int i = 0; i < k; i++) w[(k - 1 - i) * 8 +: 8] = pend[i];
        return w;
    endfunction

    function automatic int clamp(input int n);
        return (n > CAP) ? CAP : n;
    endfunction

    task automatic run_request(input int n, input int full_pct, input int hold_full);
        int exp_total = clamp(n);
        int taken = 0;
        bit have = 0;
        logic [7:0] cur = '0;
        bit fin = 0;
        pcnt = 0;
        @(negedge clk);
        req_we = 1'b1; req_count = 16'(n); byte_valid = 1'b0; fifo_full = 1'b0;
        @(negedge clk);
        for (int cyc = 0; cyc < 3000 && !fin; cyc++) begin
            req_we = (cyc == 2 && busy);
            req_count = 16'd7;
            fifo_full = (cyc < hold_full) ? 1'b1 : (int'($urandom % 100) < full_pct);
            if (!have && ($urandom % 4 != 0)) begin
                have = 1; cur = 8'($urandom);
            end
            byte_valid = have; byte_data = cur;
            #1;
            if (cyc == 0) begin
                chk(remaining == 16'(exp_total), n > CAP ? "R3" : "R2", "loaded count", remaining, exp_total);
                chk(busy, "R2", "busy after write", busy, 1);
            end else begin
                chk(remaining == 16'(exp_total - taken), "R6", "remaining", remaining, exp_total - taken);
            end
            if (fifo_full) chk(!fifo_push, "R9", "push while full", fifo_push, 0);
            if (pcnt == 4 || (taken == exp_total && pcnt > 0))
                chk(!byte_ready, "R9", "stalled while word waits", byte_ready, 0);
            if (fifo_push) begin
                chk(fifo_nbytes == 3'(pcnt), pcnt == 4 ? "R7" : "R8", "nbytes", fifo_nbytes, pcnt);
                chk(fifo_word == place_bytes(pcnt), pcnt == 4 ? "R7" : "R8", "word", fifo_word, place_bytes(pcnt));
                chk(pcnt == 4 || taken == exp_total, "R8", "short word only at end", pcnt, 4);
                chk(done == (taken == exp_total), "R10", "done with final push", done, taken == exp_total);
                pcnt = 0;
                if (done) fin = 1;
            end else begin
                chk(!done, "R10", "done without push", done, 0);
            end
            if (byte_valid && byte_ready) begin
                if (pcnt < 4) pend[pcnt] = cur;
                pcnt++;
                taken++;
                have = 0;
            end
            @(negedge clk);
        end
        req_we = 1'b0; byte_valid = 1'b0; fifo_full = 1'b0;
        chk(fin, "R10", "request finished", fin, 1);
        chk(taken == exp_total, "R5", "bytes taken", taken, exp_total);
        #1;
        chk(!busy && remaining == '0, "R10", "idle after done", {busy, remaining}, 0);
        chk(!byte_ready, "R11", "no ready when idle", byte_ready, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !byte_ready && !fifo_push && !done && remaining == '0, "R1",
            "reset state", {busy, byte_ready, fifo_push, done, remaining}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: zero count is ignored
        req_we = 1'b1; req_count = 16'd0; byte_valid = 1'b1;
        @(negedge clk);
        req_we = 1'b0;
        #1;
        chk(!busy && remaining == '0 && !byte_ready, "R4", "zero request", {busy, remaining}, 0);
        byte_valid = 1'b0;
        // R7 / R8: directed lengths
        run_request(4, 0, 0);
        run_request(1, 0, 0);
        run_request(2, 30, 0);
        run_request(3, 0, 0);
        run_request(7, 20, 0);
        // R9: FIFO held full long enough for a word to wait
        run_request(5, 0, 25);
        // R3: oversize request clamps
        run_request(1000, 10, 0);
        run_request(CAP, 40, 0);
        for (int i = 0; i < 12; i++) run_request(1 + int'($urandom % 40), int'($urandom % 60), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule